// File: doc/BRIEF.md
# Noise Sound Channel with Decaying Envelope

This block produces the pseudo-random noise voice of a programmable sound generator. A free-running divider, whose length is taken from a fixed 16-entry table, advances a 15-bit linear feedback shift register. The register can be switched between a long sequence and a short, metallic sequence by moving the second feedback tap. The channel output is a 4-bit level. It is silenced whenever the shift register's low bit is set or the note length has run out. Otherwise it carries either a fixed volume or a decaying envelope.

Software-side writes arrive as three write strobes sharing one data byte: a volume/envelope setup, a period/mode setup and a length load. An external frame sequencer supplies quarter-frame and half-frame strobes that clock the envelope and the length counter. A channel-enable level gates the length counter. The mixer and the other voices sit outside this block.

Top module: `noise_gen`

## Requirements
- R1: While rst_ni is low and on the first cycle after it rises, sample_o is 0; reset sets the shift register to 1 and the divider, envelope level, envelope divider, length counter and both setup registers to 0.
- R2: The divider runs every cycle. When it reaches 0 it produces a one-cycle step and reloads period-1, so steps come every P cycles. P is taken from period index idx as 2,4,8,16,32,48,64,80,101,127,190,254,381,508,1017,2034 for idx 0..15.
- R3: On each step the shift register moves right by one bit. The new bit 14 is bit0 XOR bit1 when the short flag is 0, and bit0 XOR bit6 when it is 1. A state of zero is replaced by 1 before shifting.
- R4: sample_o is 0 when shift register bit 0 is 1 or the length counter is 0. Otherwise it is the volume field when the constant-volume flag is 1, and the envelope level when that flag is 0.
- R5: vol_we_i stores wdata_i[3:0] as volume/envelope rate, wdata_i[4] as the constant-volume flag and wdata_i[5] as the halt/loop flag. per_we_i stores wdata_i[3:0] as the period index and wdata_i[7] as the short flag. Stored values take effect from the next cycle.
- R6: len_we_i with en_i high loads the length counter from a table indexed by wdata_i[7:3]. The table is 10,254,20,2,40,4,80,6,160,8,60,10,14,12,26,14 for indices 0..15 and 12,16,24,18,48,20,96,22,192,24,72,26,16,28,32,30 for indices 16..31. Every len_we_i sets the envelope level to 15 and reloads the envelope divider with the rate, and this takes priority over a quarter tick.
- R7: On qtr_tick_i, an envelope divider at 0 reloads the rate, and the level then decrements if it is non-zero or becomes 15 if the loop flag is set. An envelope divider that is not at 0 decrements.
- R8: On half_tick_i, the length counter decrements when it is non-zero and the halt flag is 0. With the halt flag set it holds.
- R9: While en_i is low the length counter is forced to 0, and a length load is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Channel enable level |
| vol_we_i | input | 1 | Volume/envelope setup write strobe |
| per_we_i | input | 1 | Period/mode setup write strobe |
| len_we_i | input | 1 | Length load write strobe |
| wdata_i | input | 8 | Write data shared by the three strobes |
| qtr_tick_i | input | 1 | Quarter-frame envelope clock strobe |
| half_tick_i | input | 1 | Half-frame length clock strobe |
| sample_o | output | 4 | Channel output level |

## Verification
A shift register that is stepped at the wrong time or fed from the wrong tap shows up as a mismatch in the on/off pattern of sample_o. This appears within one period of the selected table entry, which is two cycles at the fastest index. A wrong envelope level or divider appears as a wrong output amplitude on the first cycle after the offending quarter tick, as long as the shift register bit is clear then. A length counter that ends too early or too late is seen as the output falling silent on the wrong half tick. A length counter that survives a disable is seen as non-zero output while en_i is low.

// File: rtl/noise_pkg.sv
package noise_pkg;

  localparam int PER_W_DEF = 12;
  localparam int LEN_W_DEF = 8;
  localparam int VOL_W_DEF = 4;

  typedef struct packed {
    logic       halt_loop;
    logic       const_vol;
    logic [3:0] level;
  } vol_cfg_t;

  typedef struct packed {
    logic       short_mode;
    logic [3:0] idx;
  } per_cfg_t;

  function automatic logic [PER_W_DEF-1:0] period_lut(input logic [3:0] idx);
    logic [PER_W_DEF-1:0] p;
    case (idx)
      4'd0:  p = 12'd2;
      4'd1:  p = 12'd4;
      4'd2:  p = 12'd8;
      4'd3:  p = 12'd16;
      4'd4:  p = 12'd32;
      4'd5:  p = 12'd48;
      4'd6:  p = 12'd64;
      4'd7:  p = 12'd80;
      4'd8:  p = 12'd101;
      4'd9:  p = 12'd127;
      4'd10: p = 12'd190;
      4'd11: p = 12'd254;
      4'd12: p = 12'd381;
      4'd13: p = 12'd508;
      4'd14: p = 12'd1017;
      default: p = 12'd2034;
    endcase
    return p;
  endfunction

  // even indices carry the irregular values, odd indices (except 1) are idx-1
  function automatic logic [LEN_W_DEF-1:0] length_lut(input logic [4:0] idx);
    logic [LEN_W_DEF-1:0] n;
    if (idx[0] && idx != 5'd1) begin
      n = LEN_W_DEF'(idx) - 8'd1;
    end else begin
      case (idx)
        5'd0:  n = 8'd10;
        5'd1:  n = 8'd254;
        5'd2:  n = 8'd20;
        5'd4:  n = 8'd40;
        5'd6:  n = 8'd80;
        5'd8:  n = 8'd160;
        5'd10: n = 8'd60;
        5'd12: n = 8'd14;
        5'd14: n = 8'd26;
        5'd16: n = 8'd12;
        5'd18: n = 8'd24;
        5'd20: n = 8'd48;
        5'd22: n = 8'd96;
        5'd24: n = 8'd192;
        5'd26: n = 8'd72;
        5'd28: n = 8'd16;
        default: n = 8'd32;
      endcase
    end
    return n;
  endfunction

endpackage

// File: rtl/noise_timer.sv
module noise_timer #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] period_i,
  output logic         step_o
);
  logic [W-1:0] cnt_q;

  assign step_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (step_o) cnt_q <= period_i - W'(1);
    else             cnt_q <= cnt_q - W'(1);
  end

  // R2
  step_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && period_i > W'(1)) |=> !step_o);

endmodule

// File: rtl/noise_lfsr.sv
module noise_lfsr #(
  parameter int W         = 15,
  parameter int SHORT_TAP = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic short_i,
  output logic bit0_o
);
  logic [W-1:0] q, seed, nxt;
  logic         fb;

  always_comb begin
    seed = (q == '0) ? W'(1) : q;
    fb   = seed[0] ^ (short_i ? seed[SHORT_TAP] : seed[1]);
    nxt  = {fb, seed[W-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= W'(1);
    else if (step_i) q <= nxt;
  end

  assign bit0_o = q[0];

  // R3
  lfsr_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q != '0);
  // R3
  lfsr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(q));

endmodule

// File: rtl/noise_env.sv
module noise_env #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  input  logic         qtr_i,
  input  logic [W-1:0] rate_i,
  input  logic         loop_i,
  output logic [W-1:0] level_o
);
  logic [W-1:0] level_q, div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= '0;
      div_q   <= '0;
    end else if (restart_i) begin
      level_q <= '1;
      div_q   <= rate_i;
    end else if (qtr_i) begin
      if (div_q == '0) begin
        div_q <= rate_i;
        if (level_q != '0) level_q <= level_q - W'(1);
        else if (loop_i)   level_q <= '1;
      end else begin
        div_q <= div_q - W'(1);
      end
    end
  end

  assign level_o = level_q;

  // R6
  env_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> level_q == '1);
  // R7
  env_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && !qtr_i) |=> $stable(level_q));

endmodule

// File: rtl/noise_len.sv
module noise_len #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         half_i,
  input  logic         halt_i,
  output logic         active_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              cnt_q <= '0;
    else if (!en_i)                           cnt_q <= '0;
    else if (load_i)                          cnt_q <= load_val_i;
    else if (half_i && !halt_i && cnt_q != '0) cnt_q <= cnt_q - W'(1);
  end

  assign active_o = (cnt_q != '0);

  // R9
  len_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0);
  // R8
  len_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - W'(1)));
  // R8
  len_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i && halt_i) |=> $stable(cnt_q));

endmodule

// File: rtl/noise_gen.sv
module noise_gen
  import noise_pkg::*;
#(
  parameter int LFSR_W    = 15,
  parameter int SHORT_TAP = 6,
  parameter int PER_W     = PER_W_DEF,
  parameter int LEN_W     = LEN_W_DEF,
  parameter int VOL_W     = VOL_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             vol_we_i,
  input  logic             per_we_i,
  input  logic             len_we_i,
  input  logic [7:0]       wdata_i,
  input  logic             qtr_tick_i,
  input  logic             half_tick_i,
  output logic [VOL_W-1:0] sample_o
);
  vol_cfg_t          vol_q;
  per_cfg_t          per_q;
  logic              step, lfsr_bit0, len_active;
  logic [PER_W-1:0]  period;
  logic [LEN_W-1:0]  len_val;
  logic [VOL_W-1:0]  env_level, vol_field;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vol_q <= '0;
      per_q <= '0;
    end else begin
      if (vol_we_i) vol_q <= wdata_i[5:0];
      if (per_we_i) per_q <= {wdata_i[7], wdata_i[3:0]};
    end
  end

  assign period    = PER_W'(period_lut(per_q.idx));
  assign len_val   = LEN_W'(length_lut(wdata_i[7:3]));
  assign vol_field = VOL_W'(vol_q.level);

  noise_timer #(.W(PER_W)) u_timer (
    .clk_i, .rst_ni, .period_i(period), .step_o(step)
  );

  noise_lfsr #(.W(LFSR_W), .SHORT_TAP(SHORT_TAP)) u_lfsr (
    .clk_i, .rst_ni, .step_i(step), .short_i(per_q.short_mode), .bit0_o(lfsr_bit0)
  );

  noise_env #(.W(VOL_W)) u_env (
    .clk_i, .rst_ni, .restart_i(len_we_i), .qtr_i(qtr_tick_i),
    .rate_i(vol_field), .loop_i(vol_q.halt_loop), .level_o(env_level)
  );

  noise_len #(.W(LEN_W)) u_len (
    .clk_i, .rst_ni, .en_i, .load_i(len_we_i), .load_val_i(len_val),
    .half_i(half_tick_i), .halt_i(vol_q.halt_loop), .active_o(len_active)
  );

  always_comb begin
    if (lfsr_bit0 || !len_active) sample_o = '0;
    else if (vol_q.const_vol)     sample_o = vol_field;
    else                          sample_o = env_level;
  end

  // R4
  silent_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !lfsr_bit0) |=> (sample_o == '0));
  // R5
  vol_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vol_we_i |=> vol_q == $past(wdata_i[5:0]));

endmodule

// File: tb/sim_noise_gen.sv
`timescale 1ns/1ps
module sim_noise_gen;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       en = 0, vol_we = 0, per_we = 0, len_we = 0, qtr = 0, half = 0;
  logic [7:0] wdata = '0;
  logic [3:0] sample_o;

  always #4 clk = ~clk;

  noise_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .vol_we_i(vol_we), .per_we_i(per_we),
    .len_we_i(len_we), .wdata_i(wdata), .qtr_tick_i(qtr), .half_tick_i(half),
    .sample_o(sample_o)
  );

  int per_tab[16] = '{2,4,8,16,32,48,64,80,101,127,190,254,381,508,1017,2034};
  int len_tab[32] = '{10,254,20,2,40,4,80,6,160,8,60,10,14,12,26,14,
                      12,16,24,18,48,20,96,22,192,24,72,26,16,28,32,30};

  // spec model
  logic [14:0] m_lfsr;
  int          m_cnt, m_env, m_div, m_len;
  logic [5:0]  m_vol;
  logic [4:0]  m_per;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lfsr <= 15'd1; m_cnt <= 0; m_env <= 0; m_div <= 0; m_len <= 0;
      m_vol <= '0; m_per <= '0;
    end else begin : mdl
      logic [14:0] s;
      if (vol_we) m_vol <= wdata[5:0];
      if (per_we) m_per <= {wdata[7], wdata[3:0]};
      if (m_cnt == 0) begin
        m_cnt  <= per_tab[m_per[3:0]] - 1;
        s      = (m_lfsr == 0) ? 15'd1 : m_lfsr;
        m_lfsr <= {s[0] ^ (m_per[4] ? s[6] : s[1]), s[14:1]};
      end else m_cnt <= m_cnt - 1;
      if (len_we) begin
        m_env <= 15; m_div <= int'(m_vol[3:0]);
      end else if (qtr) begin
        if (m_div == 0) begin
          m_div <= int'(m_vol[3:0]);
          if (m_env != 0) m_env <= m_env - 1;
          else if (m_vol[5]) m_env <= 15;
        end else m_div <= m_div - 1;
      end
      if (!en) m_len <= 0;
      else if (len_we) m_len <= len_tab[wdata[7:3]];
      else if (half && !m_vol[5] && m_len != 0) m_len <= m_len - 1;
    end
  end

  function automatic logic [3:0] model_exp();
    if (m_lfsr[0] || m_len == 0) return 4'd0;
    return m_vol[4] ? m_vol[3:0] : 4'(m_env);
  endfunction

  // scoreboard
  typedef struct { string tag; logic [3:0] exp; } item_t;
  item_t sb_q[$];
  event  mon_ev;
  int    n_checks = 0, n_err = 0;
  bit    done = 0;

  always @(mon_ev) begin
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_checks++;
      if (sample_o !== it.exp) begin
        n_err++;
        $display("FAIL %s: sample_o=%0d expected %0d at %0t", it.tag, sample_o, it.exp, $time);
      end
    end
  end

  task automatic chk(input string tag, input logic [3:0] exp);
    @(negedge clk);
    sb_q.push_back('{tag, exp});
    ->mon_ev;
  endtask

  task automatic run_cmp(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sb_q.push_back('{tag, model_exp()});
      ->mon_ev;
    end
  endtask

  task automatic wr(input int kind, input logic [7:0] d);
    @(negedge clk);
    wdata = d;
    case (kind)
      0: vol_we = 1;
      1: per_we = 1;
      default: len_we = 1;
    endcase
    @(posedge clk); #1;
    vol_we = 0; per_we = 0; len_we = 0;
  endtask

  task automatic tick(input bit is_half);
    @(negedge clk);
    if (is_half) half = 1; else qtr = 1;
    @(posedge clk); #1;
    half = 0; qtr = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    chk("R1 in reset", 4'd0);
    chk("R1 in reset", 4'd0);
    @(negedge clk); rst_n = 1;
    chk("R1 after reset", 4'd0);
    run_cmp(4, "R1");

    // R9: disabled channel ignores length loads
    wr(0, 8'h39);               // const volume 9, halt
    wr(1, 8'h00);               // idx 0, normal
    wr(2, 8'h08);               // length idx 1
    for (int i = 0; i < 20; i++) chk("R9 load ignored", 4'd0);

    // R2 R3 R4 R5 normal mode, fast period
    en = 1;
    wr(2, 8'h08);
    run_cmp(300, "R2/R3 normal idx0");
    wr(1, 8'h02);
    run_cmp(400, "R2 idx2");

    // R3 short mode
    wr(1, 8'h83);
    run_cmp(800, "R3 short idx3");
    wr(1, 8'h80);
    run_cmp(400, "R3 short idx0");

    // R6 R7 envelope decay, no loop
    wr(1, 8'h00);
    wr(0, 8'h01);
    wr(2, 8'hF8);               // idx 31 -> 30
    run_cmp(8, "R6 restart");
    for (int i = 0; i < 36; i++) begin
      tick(0);
      run_cmp(4, "R7 decay");
    end

    // R7 loop wrap, rate 0
    wr(0, 8'h20);
    wr(2, 8'h08);
    for (int i = 0; i < 40; i++) begin
      tick(0);
      run_cmp(4, "R7 loop");
    end

    // R6 restart beats a simultaneous quarter tick
    @(negedge clk); wdata = 8'h08; len_we = 1; qtr = 1;
    @(posedge clk); #1; len_we = 0; qtr = 0;
    run_cmp(6, "R6 priority");

    // R8 halted length holds
    wr(0, 8'h35);
    wr(2, 8'h18);               // idx 3 -> 2
    for (int i = 0; i < 5; i++) begin
      tick(1);
      run_cmp(4, "R8 halt");
    end

    // R8 countdown to silence
    wr(0, 8'h15);
    wr(2, 8'h18);
    run_cmp(10, "R8 count");
    tick(1);
    run_cmp(10, "R8 count");
    tick(1);
    for (int i = 0; i < 50; i++) chk("R8 expired", 4'd0);

    // R9 disable clears length
    wr(0, 8'h37);
    wr(2, 8'h08);
    run_cmp(20, "R9 before");
    @(negedge clk); en = 0;
    for (int i = 0; i < 30; i++) chk("R9 cleared", 4'd0);
    wr(2, 8'h08);
    for (int i = 0; i < 30; i++) chk("R9 load while off", 4'd0);
    en = 1;
    run_cmp(20, "R9 re-enabled");

    done = 1;
    @(negedge clk);
    finish_run();
  end
endmodule